// File: doc/BRIEF.md
# Sectored NOR Flash Array Controller

This block is a synthesizable, scaled-down model of a sectored NOR-style flash memory. It sits behind an asynchronous-style memory bus with active-low chip enable, output enable and write enable, plus a device reset, a bus-width select and a ready output. Writes are recognised on the rising edge of the write enable while the chip enable is low, with the bus sampled on the system clock. Reads are combinational from the on-chip register array.

The address space is split into four erase sectors: a boot sector, two parameter sectors and a main sector. Their sizes are scaled from one common unit. A parameter puts the boot sector at the bottom or the top of the map. Program and sector-erase operations are started by unlock command sequences and then run for a fixed number of clock cycles. While one runs, the ready output is low and reads return a polling pattern. A one-way lock protects the boot sector from any further change.

Top module: `nor_sect_flash`

## Requirements
- R1: After power-on reset every word reads 0xFFFF, `ready` is high and the boot lock is clear.
- R2: With a unit of U words, the boot sector is 8U words, each parameter sector 4U words and the main sector 496U words. In bottom-boot mode the order from address 0 is boot, parameter A, parameter B, main. In top-boot mode it is main, parameter B, parameter A, boot. An erase changes no word outside the addressed sector.
- R3: A command starts with data 0xAA at word address 0x555, then 0x55 at 0x2AA. Both addresses are truncated to the address width, giving 0x155 and 0x0AA at the default size. Then comes a code at 0x555. Code 0xA0 programs the next write (its address and data). Code 0x80, followed by 0xAA@0x555, 0x55@0x2AA and 0x30 at any address in a sector, erases that sector. Code 0x40 sets the boot lock. Command data is taken from `dq[7:0]`.
- R4: A write that does not match the next expected step returns the sequencer to read mode with no effect on the array or on `ready`.
- R5: Programming stores old AND new, so it can only clear bits; a bit can only be set again by an erase.
- R6: A sector erase sets every word of the addressed sector to 0xFFFF.
- R7: Once the boot lock is set, a program or erase aimed at the boot sector is dropped: `ready` stays high and the boot data stays unchanged. Other sectors still accept both operations.
- R8: `ready` is low for exactly PROG_CYCLES clock cycles after a program data write and for ERASE_CYCLES cycles after an erase confirm. It only falls after a bus write.
- R9: While busy, a read returns bit 7 equal to the complement of bit 7 of the programmed data, or 0 during an erase, with every other bit 0. After completion, reads return the stored data.
- R10: With `word_mode` high all 16 data pins are driven on a read. With it low, only `dq[7:0]` are driven and `dq[14:8]` float. `dq[15]` is then an address input that selects the high byte (1) or the low byte (0) for reads and byte programs, and a byte program leaves the other byte untouched.
- R11: The block drives `dq` only while `ce_n` and `oe_n` are both low and `reset_n` is high.
- R12: Taking `reset_n` low aborts any running operation without changing the array. It raises `ready` by the next clock and clears a partly entered command, but it keeps the boot lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the bus is sampled |
| por_n | input | 1 | Power-on reset, active low, clears array and lock |
| reset_n | input | 1 | Device reset, active low, aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; write taken on its rising edge |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus with dq[15] as address LSB |
| addr | input | AW | Word address, AW = clog2(512 x UNIT_WORDS) |
| dq | inout | 16 | Data bus |
| ready | output | 1 | High when no program or erase is running |

## Verification
The hardest states to reach from the pins are those where an operation is cut off or refused. One is an erase interrupted mid-way by the device reset. Others are a command sequence half-entered before that reset, and a locked boot sector receiving an otherwise valid program or erase. The bench builds each one with exact sequences of bus writes. It pulses `reset_n` at a chosen cycle inside the erase window, then reads back data that an erase would have destroyed. It also checks that `ready` never fell for the refused boot operations. A second instance in top-boot mode, selected by its own chip enable on the shared bus, covers the mirrored sector order.

// File: rtl/nflash_pkg.sv
package nflash_pkg;

   typedef enum logic [2:0] {
      SEQ_READ,
      SEQ_UNL1,
      SEQ_UNL2,
      SEQ_PROG,
      SEQ_ERA1,
      SEQ_ERA2,
      SEQ_ERA3
   } seq_t;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PROG,
      OP_ERASE
   } op_t;

   localparam logic [1:0] SECT_BOOT = 2'd0;
   localparam logic [1:0] SECT_PARA = 2'd1;
   localparam logic [1:0] SECT_PARB = 2'd2;
   localparam logic [1:0] SECT_MAIN = 2'd3;

   localparam logic [7:0] CODE_UNL1  = 8'hAA;
   localparam logic [7:0] CODE_UNL2  = 8'h55;
   localparam logic [7:0] CODE_PROG  = 8'hA0;
   localparam logic [7:0] CODE_ERASE = 8'h80;
   localparam logic [7:0] CODE_SECT  = 8'h30;
   localparam logic [7:0] CODE_LOCK  = 8'h40;

   localparam int BOOT_UNITS  = 8;
   localparam int PARAM_UNITS = 4;
   localparam int MAIN_UNITS  = 496;
   localparam int TOTAL_UNITS = BOOT_UNITS + 2 * PARAM_UNITS + MAIN_UNITS;

endpackage

// File: rtl/nflash_cmd_seq.sv
module nflash_cmd_seq
   import nflash_pkg::*;
#(
   parameter int AW = 9
)(
   input  logic          clk,
   input  logic          por_n,
   input  logic          reset_n,
   input  logic          wr_evt,
   input  logic          busy,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_byte,
   output logic          go_prog,
   output logic          go_erase,
   output logic          go_lock
);

   localparam logic [AW-1:0] KEY_A = AW'(32'h555);
   localparam logic [AW-1:0] KEY_B = AW'(32'h2AA);

   seq_t st, st_nxt;
   logic take, at_a, at_b;

   assign take = wr_evt & ~busy;
   assign at_a = (wr_addr == KEY_A);
   assign at_b = (wr_addr == KEY_B);

   always_comb begin
      st_nxt = SEQ_READ;
      case (st)
         SEQ_READ: if (at_a && wr_byte == CODE_UNL1) st_nxt = SEQ_UNL1;
         SEQ_UNL1: if (at_b && wr_byte == CODE_UNL2) st_nxt = SEQ_UNL2;
         SEQ_UNL2: begin
            if (at_a && wr_byte == CODE_PROG)  st_nxt = SEQ_PROG;
            if (at_a && wr_byte == CODE_ERASE) st_nxt = SEQ_ERA1;
         end
         SEQ_ERA1: if (at_a && wr_byte == CODE_UNL1) st_nxt = SEQ_ERA2;
         SEQ_ERA2: if (at_b && wr_byte == CODE_UNL2) st_nxt = SEQ_ERA3;
         default:  st_nxt = SEQ_READ;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        st <= SEQ_READ;
      else if (!reset_n) st <= SEQ_READ;
      else if (take)     st <= st_nxt;
   end

   assign go_prog  = take & (st == SEQ_PROG);
   assign go_erase = take & (st == SEQ_ERA3) & (wr_byte == CODE_SECT);
   assign go_lock  = take & (st == SEQ_UNL2) & at_a & (wr_byte == CODE_LOCK);

endmodule

// File: rtl/nflash_sector_decode.sv
module nflash_sector_decode
   import nflash_pkg::*;
#(
   parameter int UNIT_WORDS = 1,
   parameter bit TOP_BOOT   = 1'b0,
   parameter int AW         = 9
)(
   input  logic [AW-1:0] addr,
   output logic [1:0]    sect_id,
   output logic [AW-1:0] sect_base,
   output logic [AW-1:0] sect_last
);

   localparam int BOOT_W  = BOOT_UNITS  * UNIT_WORDS;
   localparam int PARAM_W = PARAM_UNITS * UNIT_WORDS;
   localparam int MAIN_W  = MAIN_UNITS  * UNIT_WORDS;
   localparam int DEPTH   = TOTAL_UNITS * UNIT_WORDS;

   int a;
   assign a = int'(addr);

   generate
      if (TOP_BOOT) begin : g_top
         localparam int E0 = MAIN_W;
         localparam int E1 = E0 + PARAM_W;
         localparam int E2 = E1 + PARAM_W;
         always_comb begin
            if (a < E0) begin
               sect_id = SECT_MAIN; sect_base = '0;        sect_last = AW'(E0 - 1);
            end else if (a < E1) begin
               sect_id = SECT_PARB; sect_base = AW'(E0);   sect_last = AW'(E1 - 1);
            end else if (a < E2) begin
               sect_id = SECT_PARA; sect_base = AW'(E1);   sect_last = AW'(E2 - 1);
            end else begin
               sect_id = SECT_BOOT; sect_base = AW'(E2);   sect_last = AW'(DEPTH - 1);
            end
         end
      end else begin : g_bottom
         localparam int E0 = BOOT_W;
         localparam int E1 = E0 + PARAM_W;
         localparam int E2 = E1 + PARAM_W;
         always_comb begin
            if (a < E0) begin
               sect_id = SECT_BOOT; sect_base = '0;        sect_last = AW'(E0 - 1);
            end else if (a < E1) begin
               sect_id = SECT_PARA; sect_base = AW'(E0);   sect_last = AW'(E1 - 1);
            end else if (a < E2) begin
               sect_id = SECT_PARB; sect_base = AW'(E1);   sect_last = AW'(E2 - 1);
            end else begin
               sect_id = SECT_MAIN; sect_base = AW'(E2);   sect_last = AW'(DEPTH - 1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nflash_op_timer.sv
module nflash_op_timer #(
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 40
)(
   input  logic clk,
   input  logic por_n,
   input  logic reset_n,
   input  logic start_prog,
   input  logic start_erase,
   output logic busy,
   output logic done
);

   localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW      = $clog2(LONGEST + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!reset_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start_prog) begin
         busy <= 1'b1;
         cnt  <= CW'(PROG_CYCLES - 1);
      end else if (start_erase) begin
         busy <= 1'b1;
         cnt  <= CW'(ERASE_CYCLES - 1);
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy & (cnt == '0);

endmodule

// File: rtl/nflash_array.sv
module nflash_array #(
   parameter int DEPTH = 512,
   parameter int AW    = 9
)(
   input  logic          clk,
   input  logic          por_n,
   input  logic          commit_prog,
   input  logic          commit_erase,
   input  logic [AW-1:0] wr_addr,
   input  logic [15:0]   wr_data,
   input  logic [15:0]   wr_mask,
   input  logic [AW-1:0] era_base,
   input  logic [AW-1:0] era_last,
   input  logic [AW-1:0] rd_addr,
   output logic [15:0]   rd_data
);

   logic [15:0] cells [DEPTH];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (commit_prog) begin
         if (int'(wr_addr) < DEPTH)
            cells[wr_addr] <= cells[wr_addr] & (wr_data | ~wr_mask);
      end else if (commit_erase) begin
         for (int i = 0; i < DEPTH; i++)
            if (AW'(i) >= era_base && AW'(i) <= era_last) cells[i] <= '1;
      end
   end

   assign rd_data = (int'(rd_addr) < DEPTH) ? cells[rd_addr] : '1;

endmodule

// File: rtl/nor_sect_flash.sv
module nor_sect_flash
   import nflash_pkg::*;
#(
   parameter int UNIT_WORDS   = 1,
   parameter bit TOP_BOOT     = 1'b0,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 40,
   localparam int DEPTH       = TOTAL_UNITS * UNIT_WORDS,
   localparam int AW          = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          por_n,
   input  logic          reset_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          word_mode,
   input  logic [AW-1:0] addr,
   inout  wire  [15:0]   dq,
   output logic          ready
);

   if (UNIT_WORDS < 1)   begin : g_bad_unit  $error("UNIT_WORDS must be at least 1");   end
   if (PROG_CYCLES < 1)  begin : g_bad_prog  $error("PROG_CYCLES must be at least 1");  end
   if (ERASE_CYCLES < 1) begin : g_bad_erase $error("ERASE_CYCLES must be at least 1"); end

   logic we_q, wr_evt, busy, done;
   logic go_prog, go_erase, go_lock;
   logic start_prog, start_erase, tgt_locked, lock_q;
   logic byte_lsb, poll_bit;
   logic [1:0]    tgt_sect;
   logic [AW-1:0] tgt_base, tgt_last;
   logic [AW-1:0] op_addr, op_base, op_last;
   logic [15:0]   op_data, op_mask, rd_word, out_w;
   logic          dq_oe_lo, dq_oe_hi;
   op_t           op_kind;

   // write strobe: rising edge of we_n with the chip selected
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end
   assign wr_evt   = reset_n & ~ce_n & we_n & ~we_q;
   assign byte_lsb = word_mode ? 1'b0 : dq[15];

   nflash_cmd_seq #(.AW(AW)) u_seq (
      .clk      (clk),
      .por_n    (por_n),
      .reset_n  (reset_n),
      .wr_evt   (wr_evt),
      .busy     (busy),
      .wr_addr  (addr),
      .wr_byte  (dq[7:0]),
      .go_prog  (go_prog),
      .go_erase (go_erase),
      .go_lock  (go_lock)
   );

   nflash_sector_decode #(.UNIT_WORDS(UNIT_WORDS), .TOP_BOOT(TOP_BOOT), .AW(AW)) u_dec (
      .addr      (addr),
      .sect_id   (tgt_sect),
      .sect_base (tgt_base),
      .sect_last (tgt_last)
   );

   assign tgt_locked  = lock_q & (tgt_sect == SECT_BOOT);
   assign start_prog  = go_prog  & ~tgt_locked;
   assign start_erase = go_erase & ~tgt_locked;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       lock_q <= 1'b0;
      else if (go_lock) lock_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         op_kind  <= OP_NONE;
         op_addr  <= '0;
         op_data  <= '1;
         op_mask  <= '0;
         op_base  <= '0;
         op_last  <= '0;
         poll_bit <= 1'b1;
      end else if (start_prog) begin
         op_kind  <= OP_PROG;
         op_addr  <= addr;
         op_data  <= word_mode ? dq : {dq[7:0], dq[7:0]};
         op_mask  <= word_mode ? 16'hFFFF : (byte_lsb ? 16'hFF00 : 16'h00FF);
         poll_bit <= dq[7];
      end else if (start_erase) begin
         op_kind  <= OP_ERASE;
         op_base  <= tgt_base;
         op_last  <= tgt_last;
         poll_bit <= 1'b1;
      end
   end

   nflash_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
      .clk         (clk),
      .por_n       (por_n),
      .reset_n     (reset_n),
      .start_prog  (start_prog),
      .start_erase (start_erase),
      .busy        (busy),
      .done        (done)
   );

   nflash_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
      .clk          (clk),
      .por_n        (por_n),
      .commit_prog  (done & reset_n & (op_kind == OP_PROG)),
      .commit_erase (done & reset_n & (op_kind == OP_ERASE)),
      .wr_addr      (op_addr),
      .wr_data      (op_data),
      .wr_mask      (op_mask),
      .era_base     (op_base),
      .era_last     (op_last),
      .rd_addr      (addr),
      .rd_data      (rd_word)
   );

   always_comb begin
      if (busy)           out_w = {8'h00, ~poll_bit, 7'h00};
      else if (word_mode) out_w = rd_word;
      else                out_w = {8'h00, byte_lsb ? rd_word[15:8] : rd_word[7:0]};
   end

   assign dq_oe_lo = reset_n & ~ce_n & ~oe_n;
   assign dq_oe_hi = dq_oe_lo & word_mode;

   assign dq[7:0]  = dq_oe_lo ? out_w[7:0]  : 8'hzz;
   assign dq[15:8] = dq_oe_hi ? out_w[15:8] : 8'hzz;

   assign ready = ~busy;

endmodule

// File: rtl/nor_sect_flash_chk.sv
module nor_sect_flash_chk (
   input logic clk,
   input logic por_n,
   input logic reset_n,
   input logic ce_n,
   input logic oe_n,
   input logic word_mode,
   input logic ready,
   input logic wr_evt,
   input logic lock_q,
   input logic dq_oe_lo,
   input logic dq_oe_hi
);

   // R12
   reset_frees_chk: assert property (@(posedge clk) disable iff (!por_n)
      !reset_n |=> ready);

   // R12
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q);

   // R3
   lock_by_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(lock_q) |-> $past(wr_evt));

   // R8
   busy_by_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(ready) |-> $past(wr_evt));

   // R10
   byte_lane_chk: assert property (@(posedge clk) disable iff (!por_n)
      !word_mode |-> !dq_oe_hi);

   // R11
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      (dq_oe_lo || dq_oe_hi) |-> (!ce_n && !oe_n));

endmodule

bind nor_sect_flash nor_sect_flash_chk u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .reset_n   (reset_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .word_mode (word_mode),
   .ready     (ready),
   .wr_evt    (wr_evt),
   .lock_q    (lock_q),
   .dq_oe_lo  (dq_oe_lo),
   .dq_oe_hi  (dq_oe_hi)
);

// File: tb/nor_sect_flash_test.sv
module nor_sect_flash_test;

   localparam int PROG_N  = 8;
   localparam int ERASE_N = 40;
   localparam logic [8:0] KA = 9'h155;
   localparam logic [8:0] KB = 9'h0AA;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic por_n, reset_n, cs_n, oe_n, we_n, word_mode, sel_top;
   logic [8:0]  addr;
   logic [15:0] drv;
   logic drv_en, lsb_en, lsb_v;
   wire  [15:0] dq;
   wire  rdy_a, rdy_b, rdy;
   wire  ce_a, ce_b;
   int   n_chk = 0, n_fail = 0;

   assign dq[14:0] = drv_en ? drv[14:0] : 15'bz;
   assign dq[15]   = lsb_en ? lsb_v : (drv_en ? drv[15] : 1'bz);
   assign ce_a = cs_n | sel_top;
   assign ce_b = cs_n | ~sel_top;
   assign rdy  = sel_top ? rdy_b : rdy_a;

   nor_sect_flash #(.TOP_BOOT(1'b0), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) uut (
      .clk(clk), .por_n(por_n), .reset_n(reset_n), .ce_n(ce_a), .oe_n(oe_n), .we_n(we_n),
      .word_mode(word_mode), .addr(addr), .dq(dq), .ready(rdy_a));

   nor_sect_flash #(.TOP_BOOT(1'b1), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) uut_top (
      .clk(clk), .por_n(por_n), .reset_n(reset_n), .ce_n(ce_b), .oe_n(oe_n), .we_n(we_n),
      .word_mode(word_mode), .addr(addr), .dq(dq), .ready(rdy_b));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [8:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; drv = d; drv_en = 1'b1; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; drv_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [8:0] a, output logic [15:0] v);
      @(negedge clk); addr = a; cs_n = 1'b0; oe_n = 1'b0;
      #2 v = dq;
      cs_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic unlock();
      bus_wr(KA, 16'h00AA);
      bus_wr(KB, 16'h0055);
   endtask

   task automatic prog(input logic [8:0] a, input logic [15:0] d);
      unlock(); bus_wr(KA, 16'h00A0); bus_wr(a, d);
   endtask

   task automatic erase(input logic [8:0] a);
      unlock(); bus_wr(KA, 16'h0080); unlock(); bus_wr(a, 16'h0030);
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      while (rdy !== 1'b1 && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); reset_n = 1'b0;
      @(negedge clk);
      @(negedge clk); reset_n = 1'b1;
   endtask

   task automatic t_power_on();
      logic [15:0] v;
      chk("R1 ready after power-on", {15'h0, rdy}, 16'h0001);
      bus_rd(9'd0, v);   chk("R1 erased word 0", v, 16'hFFFF);
      bus_rd(9'd511, v); chk("R1 erased word 511", v, 16'hFFFF);
      @(negedge clk); cs_n = 1'b1; oe_n = 1'b0; #2 chk("R11 float with ce_n high", dq, 16'hzzzz);
      @(negedge clk); cs_n = 1'b0; oe_n = 1'b1; #2 chk("R11 float with oe_n high", dq, 16'hzzzz);
      cs_n = 1'b1;
   endtask

   task automatic t_program();
      logic [15:0] v; int n;
      prog(9'h100, 16'h1234); wait_rdy(n);
      chk("R8 program busy length", 16'(n), 16'(PROG_N));
      bus_rd(9'h100, v); chk("R3 R5 program result", v, 16'h1234);
      prog(9'h100, 16'hFF0F); wait_rdy(n);
      bus_rd(9'h100, v); chk("R5 reprogram ANDs", v, 16'h1204);
   endtask

   task automatic t_poll();
      logic [15:0] v; int n;
      prog(9'h101, 16'h0011);
      bus_rd(9'h101, v); chk("R9 program poll bit7 inverted", v, 16'h0080);
      wait_rdy(n);
      bus_rd(9'h101, v); chk("R9 true data after program", v, 16'h0011);
   endtask

   task automatic t_erase();
      logic [15:0] v; int n;
      prog(9'd7,  16'h0000); wait_rdy(n);
      prog(9'd8,  16'h0000); wait_rdy(n);
      prog(9'd11, 16'hAAAA); wait_rdy(n);
      prog(9'd12, 16'h00F0); wait_rdy(n);
      erase(9'd9); wait_rdy(n);
      chk("R8 erase busy length", 16'(n), 16'(ERASE_N));
      bus_rd(9'd8,  v); chk("R6 first word of sector erased", v, 16'hFFFF);
      bus_rd(9'd11, v); chk("R6 last word of sector erased", v, 16'hFFFF);
      bus_rd(9'd7,  v); chk("R2 boot below parameter A kept", v, 16'h0000);
      bus_rd(9'd12, v); chk("R2 parameter B kept", v, 16'h00F0);
      erase(9'd13);
      bus_rd(9'd13, v); chk("R9 erase poll pattern", v, 16'h0000);
      wait_rdy(n);
      bus_rd(9'd12, v); chk("R6 parameter B erased", v, 16'hFFFF);
   endtask

   task automatic t_bad_seq();
      logic [15:0] v; int n;
      bus_wr(KA, 16'h00AA);
      bus_wr(KB, 16'h0012);
      bus_wr(KA, 16'h00A0);
      bus_wr(9'h102, 16'h0000);
      chk("R4 no busy after broken sequence", {15'h0, rdy}, 16'h0001);
      bus_rd(9'h102, v); chk("R4 array unchanged", v, 16'hFFFF);
      prog(9'h102, 16'h00FF); wait_rdy(n);
      bus_rd(9'h102, v); chk("R4 read mode restored", v, 16'h00FF);
   endtask

   task automatic t_byte_lane();
      logic [15:0] v; int n;
      word_mode = 1'b0; lsb_en = 1'b1; lsb_v = 1'b1;
      prog(9'h110, 16'h003C); wait_rdy(n);
      bus_rd(9'h110, v);
      chk("R10 high byte read", {8'h00, v[7:0]}, 16'h003C);
      chk("R10 pins 14..8 float", {9'h000, v[14:8]}, {9'h000, 7'bzzzzzzz});
      lsb_v = 1'b0;
      bus_rd(9'h110, v);
      chk("R10 low byte untouched", {8'h00, v[7:0]}, 16'h00FF);
      lsb_en = 1'b0; word_mode = 1'b1;
      bus_rd(9'h110, v); chk("R10 word view of byte program", v, 16'h3CFF);
   endtask

   task automatic t_abort();
      logic [15:0] v;
      erase(9'h120);
      repeat (5) @(negedge clk);
      pulse_reset();
      chk("R12 ready after abort", {15'h0, rdy}, 16'h0001);
      bus_rd(9'h100, v); chk("R12 aborted erase left data", v, 16'h1204);
      bus_wr(KA, 16'h00AA);
      pulse_reset();
      bus_wr(KB, 16'h0055);
      bus_wr(KA, 16'h00A0);
      bus_wr(9'h103, 16'h0000);
      chk("R12 partial command cleared", {15'h0, rdy}, 16'h0001);
      bus_rd(9'h103, v); chk("R12 no program after cleared command", v, 16'hFFFF);
   endtask

   task automatic t_lock();
      logic [15:0] v; int n;
      prog(9'd2, 16'h0F0F); wait_rdy(n);
      bus_rd(9'd2, v); chk("R7 boot programmable before lock", v, 16'h0F0F);
      unlock(); bus_wr(KA, 16'h0040);
      prog(9'd3, 16'h0000);
      chk("R7 locked program stays ready", {15'h0, rdy}, 16'h0001);
      bus_rd(9'd3, v); chk("R7 locked program dropped", v, 16'hFFFF);
      erase(9'd0);
      chk("R7 locked erase stays ready", {15'h0, rdy}, 16'h0001);
      bus_rd(9'd2, v); chk("R7 locked erase dropped", v, 16'h0F0F);
      pulse_reset();
      prog(9'd4, 16'h0000);
      bus_rd(9'd4, v); chk("R12 lock survives device reset", v, 16'hFFFF);
      prog(9'd9, 16'h1111); wait_rdy(n);
      bus_rd(9'd9, v); chk("R7 other sector still programs", v, 16'h1111);
   endtask

   task automatic t_top_boot();
      logic [15:0] v; int n;
      sel_top = 1'b1;
      chk("R1 top instance ready", {15'h0, rdy}, 16'h0001);
      prog(9'd505, 16'h0000); wait_rdy(n);
      prog(9'd503, 16'h0000); wait_rdy(n);
      prog(9'd7,   16'h0000); wait_rdy(n);
      erase(9'd510); wait_rdy(n);
      bus_rd(9'd505, v); chk("R2 top boot sector erased", v, 16'hFFFF);
      bus_rd(9'd503, v); chk("R2 parameter A below top boot kept", v, 16'h0000);
      erase(9'd501); wait_rdy(n);
      bus_rd(9'd503, v); chk("R2 top parameter A erased", v, 16'hFFFF);
      bus_rd(9'd7, v);   chk("R2 low addresses are main in top mode", v, 16'h0000);
      sel_top = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      por_n = 1'b0; reset_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      word_mode = 1'b1; sel_top = 1'b0; addr = '0; drv = '0;
      drv_en = 1'b0; lsb_en = 1'b0; lsb_v = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_power_on();
      t_program();
      t_poll();
      t_erase();
      t_bad_seq();
      t_byte_lane();
      t_abort();
      t_lock();
      t_top_boot();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule